// File: doc/BRIEF.md
# Bit-Reverse Data Address Generator

This block produces data-memory addresses from a set of eight index registers and eight modify registers. Each access request names an index register, a modify register and an access form. A pre-modify access drives the sum of the two. A post-modify access drives the index value and then writes the sum back into the index register. The modify value is a signed two's-complement number, and every sum wraps modulo 2^32.

A mode register holds two bits. The reverse-enable bit mirrors the 32-bit address driven from index register 0, so that bit 0 swaps with bit 31, bit 1 with bit 30, and so on. Only the driven address is mirrored; the value kept in the register stays in plain binary. This supports FFT-style reordered buffers: software keeps a mirrored base and a mirrored stride, and the generator drives the natural addresses.

The bank-select bit switches index registers 0 to 3 to a second bank. The switch reaches accesses and register writes one cycle later than the mode write. The address and its valid strobe are registered, one cycle after the request.

Top module: `dag_bitrev`

## Requirements
- R1: After reset every index and modify register in both banks is zero, reversal is off, the primary bank is in use, `addr_vld` is 0 and `addr_out` is 0.
- R2: A write with `reg_we`=1 stores `reg_wdata` into index register `reg_num` (`reg_is_mod`=0) or modify register `reg_num` (`reg_is_mod`=1). An access in any later cycle uses the stored value.
- R3: A post-modify access (`acc_pre`=0) drives the index value. The index register then holds index+modify, wrapping modulo 2^32, with modify taken as signed.
- R4: A pre-modify access (`acc_pre`=1) drives index+modify and leaves the index register unchanged.
- R5: `addr_vld` is high in exactly the cycle after each request. Without a request, `addr_out` holds its last value.
- R6: While the reverse bit is set, an access through index register 0 drives the bit-mirrored address, in both access forms. For example, index 0x00083000 drives 0x000C1000.
- R7: Reversal never reaches the stored value. A post-modify access through index 0x00083000 with modify 0x04000000 leaves 0x04083000 in the register.
- R8: Index registers 1 to 7 always drive unreversed addresses.
- R9: A mode write with the bank bit set to 1 moves index registers 0 to 3 to the alternate bank. An access or register write in the cycle right after the mode write still uses the old bank; from the second cycle on, the new bank is used. Clearing the bit returns to the primary bank with the same timing.
- R10: When a post-modify update and a register write hit the same index register in one cycle, the register write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_we | input | 1 | Write the mode register |
| mode_rev | input | 1 | Reverse-enable value for index register 0 |
| mode_alt | input | 1 | Bank-select value for index registers 0 to 3 |
| reg_we | input | 1 | Register write strobe |
| reg_is_mod | input | 1 | 1 selects a modify register, 0 an index register |
| reg_num | input | 3 | Register number to write |
| reg_wdata | input | 32 | Register write data |
| acc_req | input | 1 | Access request |
| acc_idx | input | 3 | Index register of the access |
| acc_mod | input | 3 | Modify register of the access |
| acc_pre | input | 1 | 1 for pre-modify, 0 for post-modify |
| addr_out | output | 32 | Generated address |
| addr_vld | output | 1 | Generated address is valid |

## Verification
The assertions assume that every control input is 0 or 1 and never unknown, and that reset stays asserted for at least one clock edge before any request. They also assume that register numbers need no range check, which holds because every 3-bit value names a real register. The stimulus drives every input on the falling edge from fully defined random values and holds reset for several cycles before the first access. It keeps mode writes rare, so that each bank switch is followed by long runs of accesses that exercise both banks.

// File: rtl/dag_bitrev.sv
module dag_bitrev #(
  parameter int NIDX = 8,
  parameter int AW = 32,
  parameter int NALT = 4,
  parameter int REV_IDX = 0,
  localparam int SW = $clog2(NIDX),
  localparam int LW = $clog2(NALT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_we,
  input  logic          mode_rev,
  input  logic          mode_alt,
  input  logic          reg_we,
  input  logic          reg_is_mod,
  input  logic [SW-1:0] reg_num,
  input  logic [AW-1:0] reg_wdata,
  input  logic          acc_req,
  input  logic [SW-1:0] acc_idx,
  input  logic [SW-1:0] acc_mod,
  input  logic          acc_pre,
  output logic [AW-1:0] addr_out,
  output logic          addr_vld
);
  localparam logic [SW-1:0] REVSEL = SW'(REV_IDX);
  localparam logic [SW-1:0] ALTLIM = SW'(NALT);

  logic [AW-1:0] ireg [NIDX];
  logic [AW-1:0] areg [NALT];
  logic [AW-1:0] mreg [NIDX];
  logic rev_en, alt_sel, bank_eff;

  function automatic logic [AW-1:0] mirror(input logic [AW-1:0] v);
    for (int b = 0; b < AW; b++) mirror[b] = v[AW-1-b];
  endfunction

  wire acc_alt = bank_eff && (acc_idx < ALTLIM);
  wire wr_alt  = bank_eff && (reg_num < ALTLIM);
  wire [AW-1:0] ival = acc_alt ? areg[acc_idx[LW-1:0]] : ireg[acc_idx];
  wire [AW-1:0] sum  = ival + mreg[acc_mod];
  wire [AW-1:0] ea   = acc_pre ? sum : ival;
  wire do_rev = rev_en && (acc_idx == REVSEL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < NIDX; k++) begin
        ireg[k] <= '0;
        mreg[k] <= '0;
      end
      for (int k = 0; k < NALT; k++) areg[k] <= '0;
      rev_en   <= 1'b0;
      alt_sel  <= 1'b0;
      bank_eff <= 1'b0;
      addr_out <= '0;
      addr_vld <= 1'b0;
    end else begin
      addr_vld <= acc_req;
      bank_eff <= alt_sel;
      if (mode_we) begin
        rev_en  <= mode_rev;
        alt_sel <= mode_alt;
      end
      if (acc_req) begin
        addr_out <= do_rev ? mirror(ea) : ea;
        if (!acc_pre) begin
          if (acc_alt) areg[acc_idx[LW-1:0]] <= sum;
          else ireg[acc_idx] <= sum;
        end
      end
      if (reg_we) begin
        if (reg_is_mod) mreg[reg_num] <= reg_wdata;
        else if (wr_alt) areg[reg_num[LW-1:0]] <= reg_wdata;
        else ireg[reg_num] <= reg_wdata;
      end
    end
  end

  assert_hold_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_req |=> $stable(addr_out) && !addr_vld);
  assert_post_drives_index_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_req && !acc_pre && acc_idx != REVSEL) |=> addr_out == $past(ival));
  assert_no_rev_other_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_req && acc_pre && acc_idx != REVSEL) |=> addr_out == $past(sum));
  assert_rev_output_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_req && !acc_pre && rev_en && acc_idx == REVSEL) |=> mirror(addr_out) == $past(ival));
  assert_bank_late_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_we && mode_alt != alt_sel) |=> bank_eff != alt_sel);
endmodule

// File: tb/sim_dag_bitrev.sv
`timescale 1ns/1ps
module sim_dag_bitrev;
  logic clk = 1'b0, rst_n = 1'b0;
  logic mode_we = 0, mode_rev = 0, mode_alt = 0;
  logic reg_we = 0, reg_is_mod = 0;
  logic [2:0] reg_num = 0, acc_idx = 0, acc_mod = 0;
  logic [31:0] reg_wdata = 0, addr_out;
  logic acc_req = 0, acc_pre = 0, addr_vld;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [31:0] m_pri [8];
  logic [31:0] m_alt [4];
  logic [31:0] m_mod [8];
  bit m_rev, m_as, m_be;
  logic [31:0] m_out;

  always #2 clk = ~clk;

  dag_bitrev u0 (.clk, .rst_n, .mode_we, .mode_rev, .mode_alt, .reg_we, .reg_is_mod,
    .reg_num, .reg_wdata, .acc_req, .acc_idx, .acc_mod, .acc_pre, .addr_out, .addr_vld);

  function automatic logic [31:0] flip(input logic [31:0] v);
    logic [31:0] r;
    for (int b = 0; b < 32; b++) r[31-b] = v[b];
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input bit mwe, mrev, malt, rwe, rsm, input int rn, input logic [31:0] wd,
                      input bit req, input int ai, am, input bit pre, input string tag);
    logic [31:0] iv, sm, ea;
    bit ua;
    mode_we = mwe; mode_rev = mrev; mode_alt = malt;
    reg_we = rwe; reg_is_mod = rsm; reg_num = 3'(rn); reg_wdata = wd;
    acc_req = req; acc_idx = 3'(ai); acc_mod = 3'(am); acc_pre = pre;
    ua = m_be && ai < 4;
    iv = ua ? m_alt[ai] : m_pri[ai];
    sm = iv + m_mod[am];
    ea = pre ? sm : iv;
    @(posedge clk);
    if (req) begin
      m_out = (ai == 0 && m_rev) ? flip(ea) : ea;
      if (!pre) begin
        if (ua) m_alt[ai] = sm; else m_pri[ai] = sm;
      end
    end
    if (rwe) begin
      if (rsm) m_mod[rn] = wd;
      else if (m_be && rn < 4) m_alt[rn] = wd;
      else m_pri[rn] = wd;
    end
    m_be = m_as;
    if (mwe) begin m_rev = mrev; m_as = malt; end
    @(negedge clk);
    mode_we = 0; reg_we = 0; acc_req = 0;
    chk({tag, " vld"}, 32'(addr_vld), 32'(req));
    chk({tag, " addr"}, addr_out, m_out);
  endtask

  task automatic wr(input bit rsm, input int rn, input logic [31:0] wd, input string tag);
    step(0, m_rev, m_as, 1, rsm, rn, wd, 0, 0, 0, 0, tag);
  endtask
  task automatic acc(input int ai, am, input bit pre, input string tag);
    step(0, m_rev, m_as, 0, 0, 0, 0, 1, ai, am, pre, tag);
  endtask
  task automatic md(input bit rv, al);
    step(1, rv, al, 0, 0, 0, 0, 0, 0, 0, 0, "R9");
  endtask

  initial begin
    for (int k = 0; k < 8; k++) begin m_pri[k] = 0; m_mod[k] = 0; end
    for (int k = 0; k < 4; k++) m_alt[k] = 0;
    m_rev = 0; m_as = 0; m_be = 0; m_out = 0;
    void'($urandom(32'h5eed_0042));
    repeat (4) @(negedge clk);
    rst_n = 1;
    chk("R1 vld", 32'(addr_vld), 0);
    chk("R1 addr", addr_out, 0);
    acc(5, 3, 1, "R1");
    acc(0, 0, 0, "R1");
    // documented example
    wr(0, 0, 32'h00083000, "R2");
    wr(1, 0, 32'h04000000, "R2");
    md(1, 0);
    acc(0, 0, 0, "R6");
    chk("R6 mirrored", addr_out, 32'h000C1000);
    acc(0, 0, 1, "R6");
    chk("R6 pre", addr_out, flip(32'h08083000));
    md(0, 0);
    wr(1, 1, 32'h0, "R2");
    acc(0, 1, 0, "R7");
    chk("R7 stored", addr_out, 32'h04083000);
    md(1, 0);
    wr(0, 3, 32'h00083000, "R2");
    acc(3, 1, 1, "R8");
    chk("R8 plain", addr_out, 32'h00083000);
    // signed wrap
    wr(0, 6, 32'h00000010, "R2");
    wr(1, 2, 32'hFFFFFFE0, "R2");
    acc(6, 2, 0, "R3");
    acc(6, 1, 1, "R4");
    chk("R3 wrap", addr_out, 32'hFFFFFFF0);
    acc(6, 1, 1, "R4");
    chk("R4 unchanged", addr_out, 32'hFFFFFFF0);
    // bank latency
    md(0, 0);
    wr(0, 1, 32'h00000100, "R2");
    md(0, 1);
    acc(1, 1, 0, "R9");
    chk("R9 old bank", addr_out, 32'h00000100);
    acc(1, 1, 0, "R9");
    chk("R9 new bank", addr_out, 32'h0);
    wr(0, 1, 32'h00000777, "R9");
    md(0, 0);
    wr(0, 1, 32'h00000888, "R9");
    acc(1, 1, 0, "R9");
    chk("R9 back", addr_out, 32'h00000100);
    md(0, 1);
    acc(4, 1, 0, "R9");
    acc(1, 1, 0, "R9");
    chk("R9 alt kept", addr_out, 32'h00000888);
    // write wins over update
    md(0, 0);
    wr(1, 5, 32'h00000004, "R2");
    step(0, 0, 0, 1, 0, 2, 32'h0000ABC0, 1, 2, 5, 0, "R10");
    acc(2, 1, 1, "R10");
    chk("R10 write wins", addr_out, 32'h0000ABC0);
    repeat (3) @(negedge clk);
    chk("R5 idle hold", addr_out, m_out);
    chk("R5 idle vld", 32'(addr_vld), 0);
    // random
    for (int n = 0; n < 4000; n++) begin
      bit mw, rw, rq, pr;
      int ai;
      mw = ($urandom % 16) == 0;
      rw = ($urandom % 4) == 0;
      rq = ($urandom % 4) != 0;
      pr = $urandom % 2;
      ai = $urandom % 8;
      step(mw, $urandom % 2, $urandom % 2, rw, $urandom % 3 == 0, $urandom % 8,
           ($urandom % 2) ? $urandom : ($urandom % 256),
           rq, ai, $urandom % 8, pr,
           (ai == 0 && m_rev) ? "R6" : (ai != 0 ? "R8" : (pr ? "R4" : "R3")));
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual running expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule